// File: doc/BRIEF.md
# DSP Address Generation Unit

This block produces one effective address per accepted operation for the load/store path of a signal-processing core. It keeps a small file of address registers. Each address register has its own offset register and its own modifier register. An operation names a register and an addressing mode. The block returns the address to access and, when the mode calls for it, writes the next address back into the register at the same clock edge.

The modes are:
- linear stepping by the offset;
- circular-buffer stepping, with the buffer size held in the modifier register;
- reverse-carry stepping, for bit-reversed FFT data order;
- push and pop on a designated stack register;
- base-plus-offset forms, using the offset register or a short or long sign-extended immediate.

Operations arrive on a valid/ready port and addresses leave on a valid/ready port. The address port has a one-entry output register. While that register holds an address the consumer has not taken, `op_ready` is low, so a stalled consumer back-pressures the operation source directly. A plain configuration write port loads the three register files. It carries no handshake and takes effect at the edge where `cfg_we` is sampled high.

Top module: `agu_top`

## Requirements
- R1: After reset, `ea_valid` is low, `op_ready` is high, and every address, offset and modifier register reads zero.
- R2: An operation is accepted at a rising edge where `op_valid` and `op_ready` are both high. `op_ready` is high exactly when the output register is empty or `ea_ready` is high. The address appears on `ea_addr` with `ea_valid` high after that same edge. While `ea_valid` is high and `ea_ready` is low, `ea_valid` and `ea_addr` hold.
- R3: `cfg_file` selects the file written by the configuration port: 0 = address, 1 = offset, 2 = modifier, 3 = none. A write becomes visible to operations accepted at later edges. An operation accepted at the same edge uses the old values. If a configuration write and a register update hit the same address register at the same edge, the configuration write wins.
- R4: Mode 0 (linear) returns the address register. With update enabled, the register becomes register + offset. The offset is two's complement and the sum wraps modulo 2^24.
- R5: Mode 1 (circular) returns the address register. With update enabled and modifier M > 0, the buffer spans the aligned window of size P, where P is the smallest power of two ≥ M. The index within that window moves by the offset. The result wraps by subtracting M when it reaches M or more, and by adding M when it goes below zero. The bits above the window stay unchanged.
- R6: Mode 1 with modifier value 0 behaves exactly like mode 0.
- R7: Mode 2 (reverse carry) returns the address register. With update enabled, the register becomes the sum of register and offset, computed with the carry moving from bit 23 toward bit 0. A carry out of bit 0 is dropped.
- R8: Mode 3 (push) and mode 4 (pop) always act on register NREG-1 (7 here) and ignore `op_idx` and `op_upd`.
  - Push returns stack register − 1 and stores that value.
  - Pop returns the stack register and stores the register + 1.
- R9: Mode 5 returns address register + the sign-extended `op_imm[4:0]` and leaves the register unchanged.
- R10: Mode 6 returns address register + the sign-extended `op_imm[14:0]` and leaves the register unchanged.
- R11: Mode 7 returns address register + offset register and leaves the register unchanged.
- R12: In modes 0, 1 and 2 with `op_upd` low, the address register is left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation present |
| op_ready | output | 1 | Operation can be accepted |
| op_idx | input | 3 | Address register index |
| op_mode | input | 3 | Addressing mode (0..7, see requirements) |
| op_upd | input | 1 | Post-update enable for modes 0-2 |
| op_imm | input | 15 | Immediate offset (bits 4:0 used by mode 5) |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_file | input | 2 | Target file: 0 address, 1 offset, 2 modifier |
| cfg_idx | input | 3 | Target register index |
| cfg_data | input | 24 | Value written |
| ea_valid | output | 1 | Effective address present |
| ea_ready | input | 1 | Consumer takes the address |
| ea_addr | output | 24 | Effective address |

## Verification
The bench builds the block with its default parameters: 24-bit addresses, eight register triples, and 5-bit and 15-bit immediates. With 24-bit addresses, an offset of 2^23 exercises reverse carry out of the top bit within a few operations, and a start near 0xFFFFFF reaches the linear wrap at 2^24 at once. With eight registers, the stack register (index 7) is distinct from the registers used for the other modes, so an unchanged neighbour can be observed after push and pop. A modifier of 10 gives a window of 16, which exposes wrapping both forward and backward through the circular buffer.

// File: rtl/agu_pkg.sv
package agu_pkg;

  typedef enum logic [2:0] {
    AM_LIN  = 3'd0,
    AM_CIRC = 3'd1,
    AM_REV  = 3'd2,
    AM_PUSH = 3'd3,
    AM_POP  = 3'd4,
    AM_IMMS = 3'd5,
    AM_IMML = 3'd6,
    AM_IDX  = 3'd7
  } agu_mode_e;

  typedef enum logic [1:0] {
    RF_ADDR = 2'd0,
    RF_OFFS = 2'd1,
    RF_MODL = 2'd2,
    RF_NONE = 2'd3
  } agu_file_e;

endpackage

// File: rtl/agu_regs.sv
module agu_regs
  import agu_pkg::*;
#(
  parameter int AW   = 24,
  parameter int NREG = 8,
  localparam int IW  = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [IW-1:0] rd_idx,
  output logic [AW-1:0] rd_addr,
  output logic [AW-1:0] rd_offs,
  output logic [AW-1:0] rd_modl,
  input  logic          upd_en,
  input  logic [IW-1:0] upd_idx,
  input  logic [AW-1:0] upd_val,
  input  logic          cfg_we,
  input  agu_file_e     cfg_file,
  input  logic [IW-1:0] cfg_idx,
  input  logic [AW-1:0] cfg_data
);

  logic [NREG-1:0][AW-1:0] ar_q;
  logic [NREG-1:0][AW-1:0] off_q;
  logic [NREG-1:0][AW-1:0] mod_q;

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic cfg_hit;
    logic upd_hit;
    assign cfg_hit = cfg_we && (cfg_idx == IW'(g));
    assign upd_hit = upd_en && (upd_idx == IW'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ar_q[g] <= '0;
      end else if (cfg_hit && cfg_file == RF_ADDR) begin
        ar_q[g] <= cfg_data;
      end else if (upd_hit) begin
        ar_q[g] <= upd_val;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        off_q[g] <= '0;
        mod_q[g] <= '0;
      end else if (cfg_hit) begin
        if (cfg_file == RF_OFFS) off_q[g] <= cfg_data;
        if (cfg_file == RF_MODL) mod_q[g] <= cfg_data;
      end
    end
  end

  assign rd_addr = ar_q[rd_idx];
  assign rd_offs = off_q[rd_idx];
  assign rd_modl = mod_q[rd_idx];

  // R3
  cfg_addr_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_file == RF_ADDR) |=> ar_q[$past(cfg_idx)] == $past(cfg_data));

  // R12
  idle_regs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_we && !upd_en) |=> ($stable(ar_q) && $stable(off_q) && $stable(mod_q)));

endmodule

// File: rtl/agu_circ.sv
module agu_circ #(
  parameter int AW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] cur,
  input  logic [AW-1:0] offs,
  input  logic [AW-1:0] size,
  output logic [AW-1:0] nxt
);

  logic [AW-1:0] size_m1;
  logic [AW-1:0] mask;
  logic [AW-1:0] idx;
  logic signed [AW+1:0] s_raw;
  logic signed [AW+1:0] s_fix;
  logic signed [AW+1:0] s_size;
  logic signed [AW+1:0] s_offs;

  assign size_m1 = size - {{(AW-1){1'b0}}, 1'b1};

  // window mask: every bit at or below the top set bit of size-1
  for (genvar i = 0; i < AW; i++) begin : g_mask
    assign mask[i] = |size_m1[AW-1:i];
  end

  assign idx    = cur & mask;
  assign s_size = $signed({2'b00, size});
  assign s_offs = $signed({{2{offs[AW-1]}}, offs});
  assign s_raw  = $signed({2'b00, idx}) + s_offs;

  always_comb begin
    if (s_raw < 0)            s_fix = s_raw + s_size;
    else if (s_raw >= s_size) s_fix = s_raw - s_size;
    else                      s_fix = s_raw;
  end

  always_comb begin
    if (size == '0) nxt = cur + offs;
    else            nxt = (cur & ~mask) | (s_fix[AW-1:0] & mask);
  end

  logic in_window;
  assign in_window = (size != '0) && (idx < size) && (s_offs <= s_size) && (s_offs >= -s_size);

  // R5
  circ_stays_in_buf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_window |-> (((nxt & mask) < size) && ((nxt & ~mask) == (cur & ~mask))));

endmodule

// File: rtl/agu_revadd.sv
module agu_revadd #(
  parameter int AW = 24
) (
  input  logic [AW-1:0] a,
  input  logic [AW-1:0] b,
  output logic [AW-1:0] sum
);

  // cin[i] is the carry entering bit i from the bit above it
  logic [AW-1:0] cin;
  assign cin[AW-1] = 1'b0;

  for (genvar i = AW-1; i >= 0; i--) begin : g_bit
    assign sum[i] = a[i] ^ b[i] ^ cin[i];
    if (i > 0) begin : g_cy
      assign cin[i-1] = (a[i] & b[i]) | (cin[i] & (a[i] ^ b[i]));
    end
  end

endmodule

// File: rtl/agu_top.sv
module agu_top
  import agu_pkg::*;
#(
  parameter int AW    = 24,
  parameter int NREG  = 8,
  parameter int IMM_S = 5,
  parameter int IMM_L = 15,
  localparam int IW   = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_valid,
  output logic             op_ready,
  input  logic [IW-1:0]    op_idx,
  input  logic [2:0]       op_mode,
  input  logic             op_upd,
  input  logic [IMM_L-1:0] op_imm,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_file,
  input  logic [IW-1:0]    cfg_idx,
  input  logic [AW-1:0]    cfg_data,
  output logic             ea_valid,
  input  logic             ea_ready,
  output logic [AW-1:0]    ea_addr
);

  localparam logic [IW-1:0] SP_IDX = IW'(NREG - 1);
  localparam logic [AW-1:0] ONE    = AW'(1);

  agu_mode_e     mode;
  logic          accept;
  logic [IW-1:0] sel_idx;
  logic [AW-1:0] ar_rd, off_rd, mod_rd;
  logic [AW-1:0] lin_nxt, circ_nxt, rev_nxt;
  logic [AW-1:0] imm_s_ext, imm_l_ext;
  logic [AW-1:0] ea_calc, nxt_calc;
  logic          wr_calc;
  logic          ea_valid_q;
  logic [AW-1:0] ea_addr_q;

  assign mode     = agu_mode_e'(op_mode);
  assign op_ready = !ea_valid_q || ea_ready;
  assign accept   = op_valid && op_ready;
  assign sel_idx  = (mode == AM_PUSH || mode == AM_POP) ? SP_IDX : op_idx;

  agu_regs #(.AW(AW), .NREG(NREG)) regs_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_idx   (sel_idx),
    .rd_addr  (ar_rd),
    .rd_offs  (off_rd),
    .rd_modl  (mod_rd),
    .upd_en   (accept && wr_calc),
    .upd_idx  (sel_idx),
    .upd_val  (nxt_calc),
    .cfg_we   (cfg_we),
    .cfg_file (agu_file_e'(cfg_file)),
    .cfg_idx  (cfg_idx),
    .cfg_data (cfg_data)
  );

  agu_circ #(.AW(AW)) circ_i (
    .clk   (clk),
    .rst_n (rst_n),
    .cur   (ar_rd),
    .offs  (off_rd),
    .size  (mod_rd),
    .nxt   (circ_nxt)
  );

  agu_revadd #(.AW(AW)) rev_i (
    .a   (ar_rd),
    .b   (off_rd),
    .sum (rev_nxt)
  );

  assign lin_nxt   = ar_rd + off_rd;
  assign imm_s_ext = {{(AW-IMM_S){op_imm[IMM_S-1]}}, op_imm[IMM_S-1:0]};
  assign imm_l_ext = {{(AW-IMM_L){op_imm[IMM_L-1]}}, op_imm};

  always_comb begin
    ea_calc  = ar_rd;
    nxt_calc = ar_rd;
    wr_calc  = 1'b0;
    unique case (mode)
      AM_LIN:  begin nxt_calc = lin_nxt;  wr_calc = op_upd; end
      AM_CIRC: begin nxt_calc = circ_nxt; wr_calc = op_upd; end
      AM_REV:  begin nxt_calc = rev_nxt;  wr_calc = op_upd; end
      AM_PUSH: begin ea_calc = ar_rd - ONE; nxt_calc = ar_rd - ONE; wr_calc = 1'b1; end
      AM_POP:  begin nxt_calc = ar_rd + ONE; wr_calc = 1'b1; end
      AM_IMMS: ea_calc = ar_rd + imm_s_ext;
      AM_IMML: ea_calc = ar_rd + imm_l_ext;
      AM_IDX:  ea_calc = lin_nxt;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ea_valid_q <= 1'b0;
      ea_addr_q  <= '0;
    end else if (accept) begin
      ea_valid_q <= 1'b1;
      ea_addr_q  <= ea_calc;
    end else if (ea_ready) begin
      ea_valid_q <= 1'b0;
    end
  end

  assign ea_valid = ea_valid_q;
  assign ea_addr  = ea_addr_q;

  // R2
  accept_gives_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> ea_valid);

  // R2
  stall_holds_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ea_valid && !ea_ready) |=> (ea_valid && $stable(ea_addr)));

endmodule

// File: tb/agu_top_tb_top.sv
module agu_top_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic        op_ready;
  logic [2:0]  op_idx = '0;
  logic [2:0]  op_mode = '0;
  logic        op_upd = 1'b0;
  logic [14:0] op_imm = '0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_file = '0;
  logic [2:0]  cfg_idx = '0;
  logic [23:0] cfg_data = '0;
  logic        ea_valid;
  logic        ea_ready = 1'b1;
  logic [23:0] ea_addr;

  always #10 clk = ~clk;

  agu_top dut_i (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
    .op_idx(op_idx), .op_mode(op_mode), .op_upd(op_upd), .op_imm(op_imm),
    .cfg_we(cfg_we), .cfg_file(cfg_file), .cfg_idx(cfg_idx), .cfg_data(cfg_data),
    .ea_valid(ea_valid), .ea_ready(ea_ready), .ea_addr(ea_addr)
  );

  typedef struct { logic [23:0] ea; string tag; } exp_t;
  exp_t sb_q[$];
  int n_total = 0;
  int n_pass  = 0;
  logic [23:0] m_ar [8];
  logic [23:0] m_off[8];
  logic [23:0] m_mod[8];
  bit bp_en = 1'b0;
  bit done  = 1'b0;

  task automatic chk(bit ok, string tag, logic [23:0] act, logic [23:0] exp);
    n_total++;
    if (ok) n_pass++;
    else $display("FAIL %s actual=%h expected=%h", tag, act, exp);
  endtask

  function automatic logic [23:0] m_rev(logic [23:0] a, logic [23:0] b);
    logic [23:0] ra, rb, rs, r;
    for (int i = 0; i < 24; i++) begin ra[i] = a[23-i]; rb[i] = b[23-i]; end
    rs = ra + rb;
    for (int i = 0; i < 24; i++) r[i] = rs[23-i];
    return r;
  endfunction

  function automatic logic [23:0] m_circ(logic [23:0] a, logic [23:0] off, logic [23:0] m);
    int p, idx, so, s;
    if (m == 0) return a + off;
    p = 1;
    while (p < int'(m)) p = p * 2;
    idx = int'(a) % p;
    so  = int'({{8{off[23]}}, off});
    s   = idx + so;
    if (s < 0) s = s + int'(m);
    else if (s >= int'(m)) s = s - int'(m);
    return (a - 24'(idx)) + 24'(s);
  endfunction

  // compute the expected address, advance the model, then drive the port
  task automatic issue(int mode, int idx, bit upd, logic [14:0] imm, string tag,
                       bit wcfg = 0, int file = 0, int cidx = 0, logic [23:0] cdata = 0);
    int r;
    logic [23:0] a, e, n;
    bit w;
    r = (mode == 3 || mode == 4) ? 7 : idx;
    a = m_ar[r];
    e = a; n = a; w = 0;
    case (mode)
      0: begin n = a + m_off[r]; w = upd; end
      1: begin n = m_circ(a, m_off[r], m_mod[r]); w = upd; end
      2: begin n = m_rev(a, m_off[r]); w = upd; end
      3: begin e = a - 1; n = a - 1; w = 1; end
      4: begin n = a + 1; w = 1; end
      5: e = a + {{19{imm[4]}}, imm[4:0]};
      6: e = a + {{9{imm[14]}}, imm};
      default: e = a + m_off[r];
    endcase
    sb_q.push_back('{ea: e, tag: tag});
    if (w) m_ar[r] = n;
    if (wcfg) begin
      if (file == 0) m_ar[cidx] = cdata;
      if (file == 1) m_off[cidx] = cdata;
      if (file == 2) m_mod[cidx] = cdata;
    end
    @(negedge clk); #6;
    op_valid = 1; op_mode = 3'(mode); op_idx = 3'(idx); op_upd = upd; op_imm = imm;
    cfg_we = wcfg; cfg_file = 2'(file); cfg_idx = 3'(cidx); cfg_data = cdata;
    while (!op_ready) begin @(negedge clk); #6; end
    @(posedge clk); #1;
    op_valid = 0; cfg_we = 0;
  endtask

  task automatic cfg(int file, int idx, logic [23:0] d);
    if (file == 0) m_ar[idx] = d;
    if (file == 1) m_off[idx] = d;
    if (file == 2) m_mod[idx] = d;
    @(negedge clk); #6;
    cfg_we = 1; cfg_file = 2'(file); cfg_idx = 3'(idx); cfg_data = d;
    @(posedge clk); #1;
    cfg_we = 0;
  endtask

  task automatic drain();
    int k = 0;
    while (sb_q.size() != 0 && k < 200) begin @(negedge clk); k++; end
  endtask

  // back-pressure pattern
  int cyc = 0;
  initial forever begin
    @(negedge clk); #2;
    cyc++;
    ea_ready = bp_en ? ((cyc % 3) != 0) : 1'b1;
  end

  // monitor / scoreboard
  bit held_v = 0;
  logic [23:0] held_d = '0;
  initial forever begin
    @(negedge clk); #5;
    if (rst_n) begin
      if (held_v) chk(ea_valid && ea_addr == held_d, "R2 stall hold", ea_addr, held_d);
      held_v = ea_valid && !ea_ready;
      held_d = ea_addr;
      if (ea_valid && ea_ready) begin
        if (sb_q.size() == 0) chk(0, "R2 unexpected output", ea_addr, 24'h0);
        else begin
          exp_t x;
          x = sb_q.pop_front();
          chk(ea_addr == x.ea, x.tag, ea_addr, x.ea);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      chk(0, "watchdog", 24'h0, 24'h0);
      $display("%0d/%0d checks passed", n_pass, n_total);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) begin m_ar[i] = 0; m_off[i] = 0; m_mod[i] = 0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk); #5;
    chk(!ea_valid, "R1 ea_valid low", {23'h0, ea_valid}, 24'h0);
    chk(op_ready,  "R1 op_ready high", {23'h0, op_ready}, 24'h1);
    issue(0, 0, 0, 0, "R1 reg0 zero");
    issue(7, 5, 0, 0, "R1 reg5 addr+off zero");

    // R4 linear stepping, R12 no update
    cfg(0, 1, 24'h000100); cfg(1, 1, 24'h000003);
    for (int i = 0; i < 3; i++) issue(0, 1, 1, 0, "R4 linear step");
    issue(0, 1, 0, 0, "R12 linear no update");
    issue(0, 1, 0, 0, "R12 linear no update again");
    cfg(0, 2, 24'hFFFFFE); cfg(1, 2, 24'h000005);
    issue(0, 2, 1, 0, "R4 before wrap");
    issue(0, 2, 1, 0, "R4 wrap 2^24");
    cfg(1, 2, 24'hFFFFFE);
    issue(0, 2, 1, 0, "R4 negative offset");
    issue(0, 2, 0, 0, "R4 negative offset result");

    // R5 circular buffer
    cfg(0, 3, 24'h000200); cfg(1, 3, 24'h000003); cfg(2, 3, 24'h00000A);
    for (int i = 0; i < 6; i++) issue(1, 3, 1, 0, "R5 circular forward");
    cfg(0, 3, 24'h000201); cfg(1, 3, 24'hFFFFFC);
    for (int i = 0; i < 5; i++) issue(1, 3, 1, 0, "R5 circular backward");
    issue(1, 3, 0, 0, "R12 circular no update");
    issue(1, 3, 0, 0, "R12 circular no update again");

    // R6 modifier zero
    cfg(0, 4, 24'h0003F0); cfg(1, 4, 24'h000020);
    for (int i = 0; i < 3; i++) issue(1, 4, 1, 0, "R6 modulus zero linear");

    // R7 reverse carry
    cfg(0, 5, 24'h000000); cfg(1, 5, 24'h800000);
    for (int i = 0; i < 5; i++) issue(2, 5, 1, 0, "R7 reverse carry top");
    cfg(0, 5, 24'h000000); cfg(1, 5, 24'h000004);
    for (int i = 0; i < 6; i++) issue(2, 5, 1, 0, "R7 reverse carry low");
    issue(2, 5, 0, 0, "R12 reverse no update");

    // R8 stack
    cfg(0, 7, 24'h001000);
    issue(3, 2, 0, 0, "R8 push");
    issue(3, 2, 0, 0, "R8 push second");
    issue(4, 2, 0, 0, "R8 pop");
    issue(4, 1, 0, 0, "R8 pop second");
    issue(0, 7, 0, 0, "R8 stack reg restored");
    issue(0, 2, 0, 0, "R8 op_idx ignored reg2 unchanged");

    // R9 / R10 immediates, R11 indexed
    cfg(0, 1, 24'h000400); cfg(1, 1, 24'h000010);
    issue(5, 1, 1, 15'h001F, "R9 short imm -1");
    issue(5, 1, 1, 15'h000F, "R9 short imm +15");
    issue(5, 1, 0, 15'h7FF0, "R9 short imm upper bits ignored");
    issue(6, 1, 1, 15'h7FFF, "R10 long imm -1");
    issue(6, 1, 0, 15'h4000, "R10 long imm most negative");
    issue(6, 1, 0, 15'h3FFF, "R10 long imm most positive");
    issue(7, 1, 1, 0, "R11 indexed");
    issue(0, 1, 0, 0, "R11 R9 R10 register unchanged");

    // R3 same-edge configuration
    issue(0, 1, 1, 0, "R3 old value used", 1, 0, 1, 24'h000500);
    issue(0, 1, 0, 0, "R3 config wins over update");
    issue(0, 1, 1, 0, "R3 old offset used", 1, 1, 1, 24'h000100);
    issue(0, 1, 0, 0, "R3 new offset visible");
    issue(7, 1, 0, 0, "R3 offset write landed");
    issue(0, 6, 0, 0, "R3 none file no effect", 1, 3, 6, 24'h123456);
    issue(0, 6, 0, 0, "R3 none file still zero");

    // R2 back-pressure
    drain();
    bp_en = 1;
    cfg(0, 0, 24'h00A000); cfg(1, 0, 24'h000001);
    for (int i = 0; i < 10; i++) issue(0, 0, 1, 0, "R2 back-pressure stream");
    drain();
    bp_en = 0;
    drain();
    chk(sb_q.size() == 0, "R2 all outputs seen", 24'(sb_q.size()), 24'h0);
    done = 1;
    $display("%0d/%0d checks passed", n_pass, n_total);
    $finish;
  end

endmodule